// File: doc/BRIEF.md
# Audio Master, Bit and Frame Clock Generator

This block divides a fast system clock down to the three clocks an audio serial port needs. These are a master clock for an external codec, a bit clock, and a frame clock that marks the left and right channel slots at the sample rate fs. It also gives a companion serial engine one-cycle pulses on every bit-clock rising and falling edge, and on every frame-clock toggle.

The master clock always runs at the system clock divided by `2*MCLK_HALF`. The configured ratio of master clock to fs therefore sets the divide from master clock to bit clock. The ratio comes from a 3-bit multiplier code plus a family bit that picks either the power-of-two ratios or the three-times-power-of-two ratios. A width bit selects 32·fs framing (16-bit slots) or 48·fs framing (24-bit slots). The configuration is captured only while the port is not running.

The master clock can run on its own, with no transfer enabled, so that a codec can lock before any data moves. The bit and frame clocks start only when a transfer is enabled, and they start on a master-clock rising edge.

Top module: `aclk_gen`

## Requirements
- R1: While `run_i`=1, `gate_i`=0 and the captured configuration is legal, `mclk_o` toggles every `MCLK_HALF` system cycles (default 2), so its high and low halves are each `MCLK_HALF` cycles long.
- R2: Ratio decoding. With `fam3_i`=0, multiplier codes 0, 1, 2, 3 and 4 give master/fs ratios of 512, 256, 128, 64 and 32. With `fam3_i`=1, codes 0, 1, 2 and 3 give 384, 192, 96 and 48. Frame length is 32 bit periods when `wide_i`=0 and 48 when `wide_i`=1. Each bit-clock half lasts (ratio / frame length) × `MCLK_HALF` system cycles, and every bit-clock rising edge falls on a master-clock edge.
- R3: `fclk_o` is 0 in the first slot after the bit clock starts. It changes only together with a bit-clock falling edge, once every 16 bit periods (`wide_i`=0) or 24 bit periods (`wide_i`=1).
- R4: Codes 5–7 with `fam3_i`=0, and codes 4–7 with `fam3_i`=1, are illegal. `cfg_bad_o` is then 1, and `mclk_o`, `bclk_o` and `fclk_o` stay 0.
- R5: A legal ratio that is not a whole multiple of the frame length sets `cfg_err_o`. Examples are `fam3_i`=0 with `wide_i`=1, and ratio 48 with `wide_i`=0. The bit clock, frame clock and their pulses then stay 0, while `mclk_o` still runs per R1.
- R6: The multiplier, family and width inputs are captured on every clock edge where `run_i` is 0. Changes made while `run_i` is 1 have no effect on the clocks.
- R7: With `xfer_i`=0, `bclk_o` and `fclk_o` are 0 while `mclk_o` may run.
- R8: One cycle after `run_i`=0 or `gate_i`=1 is sampled, `mclk_o`, `bclk_o` and `fclk_o` are all 0.
- R9: `bclk_rise_o` is 1 for exactly the first system cycle in which `bclk_o` reads 1. `bclk_fall_o` is 1 for exactly the first cycle of each running low half.
- R10: `frame_stb_o` is 1 for exactly the system cycle in which `fclk_o` shows its new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Port running; 0 lets configuration be captured |
| gate_i | input | 1 | Clock gate; 1 holds all clocks low |
| xfer_i | input | 1 | Transfer enable for bit and frame clocks |
| mult_i | input | 3 | Ratio multiplier code |
| fam3_i | input | 1 | Ratio family: 0 power-of-two, 1 three-times-power-of-two |
| wide_i | input | 1 | 1 selects 48·fs framing with 24-bit slots |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame (left/right) clock |
| bclk_rise_o | output | 1 | Pulse with each bit-clock rise |
| bclk_fall_o | output | 1 | Pulse with each bit-clock fall |
| frame_stb_o | output | 1 | Pulse with each frame-clock toggle |
| cfg_bad_o | output | 1 | Captured ratio code is illegal |
| cfg_err_o | output | 1 | Ratio does not divide into the frame length |

## Verification
The properties take for granted that reset is asserted from time zero. They also assume that the run, gate and transfer inputs are plain levels sampled at the rising edge, so a disable always lands on a clock edge at which every output register clears together. The stimulus changes every input only at falling clock edges. It alters the configuration inputs only with `run_i` low, except in the one case that checks those changes are ignored while running. It always gives the capture register several idle cycles before raising `run_i`.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  localparam int MULT_W = 3;
  localparam int CODES  = 1 << MULT_W;

  // captured port configuration
  typedef struct packed {
    logic [MULT_W-1:0] mult;
    logic              fam3;
    logic              wide;
  } aclk_cfg_t;

endpackage

// File: rtl/aclk_cfg.sv
module aclk_cfg
  import aclk_pkg::*;
#(
  parameter int MCLK_HALF  = 2,
  parameter int RATIO2_TOP = 512,
  parameter int RATIO3_TOP = 384,
  parameter int N2_CODES   = 5,
  parameter int N3_CODES   = 4,
  parameter int SLOT_STD   = 16,
  parameter int SLOT_WIDE  = 24,
  parameter int HALF_W     = 12,
  parameter int SLOT_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  aclk_cfg_t         cfg_i,
  output aclk_cfg_t         cfg_q_o,
  output logic              legal_o,
  output logic              div_ok_o,
  output logic [HALF_W-1:0] bhalf_o,
  output logic [SLOT_W-1:0] slot_o
);

  localparam int FR_STD  = 2 * SLOT_STD;
  localparam int FR_WIDE = 2 * SLOT_WIDE;

  typedef struct packed {
    logic              legal;
    logic              ok_std;
    logic              ok_wide;
    logic [HALF_W-1:0] half_std;
    logic [HALF_W-1:0] half_wide;
  } ent_t;

  function automatic ent_t mk_ent(input int r);
    ent_t e;
    e.legal     = (r != 0);
    e.ok_std    = (r != 0) && (r >= FR_STD)  && ((r % FR_STD)  == 0);
    e.ok_wide   = (r != 0) && (r >= FR_WIDE) && ((r % FR_WIDE) == 0);
    e.half_std  = HALF_W'((r / FR_STD)  * MCLK_HALF);
    e.half_wide = HALF_W'((r / FR_WIDE) * MCLK_HALF);
    return e;
  endfunction

  // capture register with explicit enable
  aclk_cfg_t cfg_q, cfg_d;
  logic      cap_en;

  assign cap_en = ~run_i;

  always_comb begin
    cfg_d = cfg_q;
    if (cap_en) cfg_d = cfg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  // constant ratio tables, one entry per multiplier code and family
  ent_t tab2 [CODES];
  ent_t tab3 [CODES];

  for (genvar i = 0; i < CODES; i++) begin : g_code
    localparam int R2 = (i < N2_CODES) ? (RATIO2_TOP >> i) : 0;
    localparam int R3 = (i < N3_CODES) ? (RATIO3_TOP >> i) : 0;
    assign tab2[i] = mk_ent(R2);
    assign tab3[i] = mk_ent(R3);
  end

  ent_t sel;

  always_comb begin
    sel      = cfg_q.fam3 ? tab3[cfg_q.mult] : tab2[cfg_q.mult];
    legal_o  = sel.legal;
    div_ok_o = cfg_q.wide ? sel.ok_wide   : sel.ok_std;
    bhalf_o  = cfg_q.wide ? sel.half_wide : sel.half_std;
    slot_o   = cfg_q.wide ? SLOT_W'(SLOT_WIDE) : SLOT_W'(SLOT_STD);
  end

  assign cfg_q_o = cfg_q;

endmodule

// File: rtl/aclk_mclk.sv
module aclk_mclk #(
  parameter int MCLK_HALF = 2,
  localparam int CNT_W    = $clog2(MCLK_HALF + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic mclk_o,
  output logic rise_next_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mclk_q, mclk_d;
  logic             wrap;

  assign wrap = (cnt_q == CNT_W'(MCLK_HALF - 1));

  always_comb begin
    cnt_d  = cnt_q;
    mclk_d = mclk_q;
    if (!en_i) begin
      cnt_d  = '0;
      mclk_d = 1'b0;
    end else if (wrap) begin
      cnt_d  = '0;
      mclk_d = ~mclk_q;
    end else begin
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      mclk_q <= mclk_d;
    end
  end

  assign mclk_o      = mclk_q;
  // the coming edge raises the master clock
  assign rise_next_o = en_i & wrap & ~mclk_q;

endmodule

// File: rtl/aclk_bclk.sv
module aclk_bclk #(
  parameter int HALF_W = 12,
  parameter int SLOT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              bclk_o,
  output logic              rise_o,
  output logic              fall_o,
  output logic              fclk_o,
  output logic              fstb_o
);

  logic              act_q, act_d;
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic [SLOT_W-1:0] bits_q, bits_d;
  logic              bclk_q, bclk_d;
  logic              fclk_q, fclk_d;
  logic              rise_q, rise_d;
  logic              fall_q, fall_d;
  logic              fstb_q, fstb_d;
  logic              half_end, slot_end;

  assign half_end = (cnt_q == half_i - HALF_W'(1));
  assign slot_end = (bits_q == slot_i - SLOT_W'(1));

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    bits_d = bits_q;
    bclk_d = bclk_q;
    fclk_d = fclk_q;
    rise_d = 1'b0;
    fall_d = 1'b0;
    fstb_d = 1'b0;
    if (!en_i) begin
      act_d  = 1'b0;
      cnt_d  = '0;
      bits_d = '0;
      bclk_d = 1'b0;
      fclk_d = 1'b0;
    end else if (!act_q) begin
      // wait for a master-clock rise so both clocks share phase
      if (start_i) begin
        act_d = 1'b1;
        cnt_d = '0;
      end
    end else if (half_end) begin
      cnt_d  = '0;
      bclk_d = ~bclk_q;
      rise_d = ~bclk_q;
      fall_d = bclk_q;
      if (bclk_q) begin
        if (slot_end) begin
          bits_d = '0;
          fclk_d = ~fclk_q;
          fstb_d = 1'b1;
        end else begin
          bits_d = bits_q + SLOT_W'(1);
        end
      end
    end else begin
      cnt_d = cnt_q + HALF_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      bits_q <= '0;
      bclk_q <= 1'b0;
      fclk_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      fstb_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      bits_q <= bits_d;
      bclk_q <= bclk_d;
      fclk_q <= fclk_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
      fstb_q <= fstb_d;
    end
  end

  assign bclk_o = bclk_q;
  assign fclk_o = fclk_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign fstb_o = fstb_q;

endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
  import aclk_pkg::*;
#(
  parameter int MCLK_HALF  = 2,
  parameter int RATIO2_TOP = 512,
  parameter int RATIO3_TOP = 384,
  parameter int N2_CODES   = 5,
  parameter int N3_CODES   = 4,
  parameter int SLOT_STD   = 16,
  parameter int SLOT_WIDE  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              gate_i,
  input  logic              xfer_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic              fam3_i,
  input  logic              wide_i,
  output logic              mclk_o,
  output logic              bclk_o,
  output logic              fclk_o,
  output logic              bclk_rise_o,
  output logic              bclk_fall_o,
  output logic              frame_stb_o,
  output logic              cfg_bad_o,
  output logic              cfg_err_o
);

  localparam int TOP_RATIO = (RATIO2_TOP > RATIO3_TOP) ? RATIO2_TOP : RATIO3_TOP;
  localparam int TOP_SLOT  = (SLOT_WIDE > SLOT_STD) ? SLOT_WIDE : SLOT_STD;
  localparam int HALF_W    = $clog2(TOP_RATIO * MCLK_HALF + 1);
  localparam int SLOT_W    = $clog2(TOP_SLOT + 1);

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  aclk_cfg_t         cfg_in, cfg_q;
  logic              legal, div_ok;
  logic [HALF_W-1:0] bhalf;
  logic [SLOT_W-1:0] slot;
  logic              mclk_en, bclk_en, rise_next;

  assign cfg_in.mult = mult_i;
  assign cfg_in.fam3 = fam3_i;
  assign cfg_in.wide = wide_i;

  aclk_cfg #(
    .MCLK_HALF (MCLK_HALF),
    .RATIO2_TOP(RATIO2_TOP),
    .RATIO3_TOP(RATIO3_TOP),
    .N2_CODES  (N2_CODES),
    .N3_CODES  (N3_CODES),
    .SLOT_STD  (SLOT_STD),
    .SLOT_WIDE (SLOT_WIDE),
    .HALF_W    (HALF_W),
    .SLOT_W    (SLOT_W)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .run_i   (run_i),
    .cfg_i   (cfg_in),
    .cfg_q_o (cfg_q),
    .legal_o (legal),
    .div_ok_o(div_ok),
    .bhalf_o (bhalf),
    .slot_o  (slot)
  );

  assign mclk_en = run_i & ~gate_i & legal;
  assign bclk_en = mclk_en & xfer_i & div_ok;

  aclk_mclk #(
    .MCLK_HALF(MCLK_HALF)
  ) u_mclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .en_i       (mclk_en),
    .mclk_o     (mclk_o),
    .rise_next_o(rise_next)
  );

  aclk_bclk #(
    .HALF_W(HALF_W),
    .SLOT_W(SLOT_W)
  ) u_bclk (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .en_i   (bclk_en),
    .start_i(rise_next),
    .half_i (bhalf),
    .slot_i (slot),
    .bclk_o (bclk_o),
    .rise_o (bclk_rise_o),
    .fall_o (bclk_fall_o),
    .fclk_o (fclk_o),
    .fstb_o (frame_stb_o)
  );

  assign cfg_bad_o = ~legal;
  assign cfg_err_o = legal & ~div_ok;

endmodule

// File: rtl/aclk_gen_chk.sv
module aclk_gen_chk
  import aclk_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      run_i,
  input logic      gate_i,
  input logic      xfer_i,
  input logic      mclk_o,
  input logic      bclk_o,
  input logic      fclk_o,
  input logic      bclk_rise_o,
  input logic      bclk_fall_o,
  input logic      frame_stb_o,
  input logic      cfg_bad_o,
  input logic      cfg_err_o,
  input aclk_cfg_t cfg_q
);

  AST_BAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_bad_o |-> (!mclk_o && !bclk_o && !fclk_o)); // R4

  AST_DIVERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!bclk_o && !fclk_o && !bclk_rise_o && !frame_stb_o)); // R5

  AST_BCLK_ON_MCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bclk_o) |-> !$stable(mclk_o)); // R2

  AST_FRAME_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fclk_o) |-> $fell(bclk_o)); // R3

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_i) |-> $stable(cfg_q)); // R6

  AST_NOXFER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> (!bclk_o && !fclk_o)); // R7

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i || gate_i) |=> (!mclk_o && !bclk_o && !fclk_o)); // R8

  AST_RISE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bclk_o) |-> bclk_rise_o); // R9

  AST_FALL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_fall_o |-> $fell(bclk_o)); // R9

  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bclk_rise_o, bclk_fall_o})); // R9

  AST_FSTB_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_o |-> (!$stable(fclk_o) && $fell(bclk_o))); // R10

endmodule

bind aclk_gen aclk_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_i),
  .gate_i     (gate_i),
  .xfer_i     (xfer_i),
  .mclk_o     (mclk_o),
  .bclk_o     (bclk_o),
  .fclk_o     (fclk_o),
  .bclk_rise_o(bclk_rise_o),
  .bclk_fall_o(bclk_fall_o),
  .frame_stb_o(frame_stb_o),
  .cfg_bad_o  (cfg_bad_o),
  .cfg_err_o  (cfg_err_o),
  .cfg_q      (cfg_q)
);

// File: tb/tb_aclk_gen.sv
`timescale 1ns/1ps
module tb_aclk_gen;

  localparam int MH  = 2;
  localparam int LIM = 4000;

  logic       clk;
  logic       rst_n;
  logic       run, gate, xfer, fam3, wide;
  logic [2:0] mult;
  logic       mclk_o, bclk_o, fclk_o, bclk_rise_o, bclk_fall_o, frame_stb_o;
  logic       cfg_bad_o, cfg_err_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct {
    bit bad;
    bit err;
    int bhalf;
    int slot;
  } exp_t;

  exp_t exp_q[$];
  event go_ev, done_ev;

  aclk_gen #(.MCLK_HALF(MH)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .run_i      (run),
    .gate_i     (gate),
    .xfer_i     (xfer),
    .mult_i     (mult),
    .fam3_i     (fam3),
    .wide_i     (wide),
    .mclk_o     (mclk_o),
    .bclk_o     (bclk_o),
    .fclk_o     (fclk_o),
    .bclk_rise_o(bclk_rise_o),
    .bclk_fall_o(bclk_fall_o),
    .frame_stb_o(frame_stb_o),
    .cfg_bad_o  (cfg_bad_o),
    .cfg_err_o  (cfg_err_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // expected values straight from the requirement tables
  function automatic exp_t expect_of(input int m, input bit f, input bit w);
    exp_t e;
    int r, fb;
    r = 0;
    if (!f && m <= 4) r = 512 >> m;
    if (f && m <= 3)  r = 384 >> m;
    fb      = w ? 48 : 32;
    e.bad   = (r == 0);
    e.err   = !e.bad && ((r % fb) != 0 || r < fb);
    e.bhalf = (r / fb) * MH;
    e.slot  = w ? 24 : 16;
    return e;
  endfunction

  task automatic measure_mclk(input string req);
    int g, hi, lo;
    logic pm;
    g = 0; pm = mclk_o;
    @(negedge clk);
    while (!(pm == 1'b0 && mclk_o == 1'b1) && g < LIM) begin
      pm = mclk_o; @(negedge clk); g++;
    end
    check(g < LIM, req, g, LIM);
    hi = 0;
    while (mclk_o == 1'b1 && hi < LIM) begin hi++; @(negedge clk); end
    lo = 0;
    while (mclk_o == 1'b0 && lo < LIM) begin lo++; @(negedge clk); end
    check(hi == MH, req, hi, MH);
    check(lo == MH, req, lo, MH);
  endtask

  task automatic check_case(input exp_t e);
    int n, g, hi, lo;
    logic pb, pf;
    if (e.bad) begin
      @(negedge clk);
      check(cfg_bad_o == 1'b1, "R4", cfg_bad_o, 1);
      n = 0;
      repeat (64) begin
        @(negedge clk);
        if (mclk_o | bclk_o | fclk_o) n++;
      end
      check(n == 0, "R4", n, 0);
      return;
    end
    @(negedge clk);
    check(cfg_bad_o == 1'b0, "R4", cfg_bad_o, 0);
    check(cfg_err_o == e.err, "R5", cfg_err_o, e.err);
    if (e.err) begin
      n = 0;
      repeat (64) begin
        @(negedge clk);
        if (bclk_o | fclk_o | bclk_rise_o | frame_stb_o) n++;
      end
      check(n == 0, "R5", n, 0);
      measure_mclk("R5");
      return;
    end
    // frame clock: first slot low, then toggles every slot bits
    check(fclk_o == 1'b0, "R3", fclk_o, 0);
    pb = bclk_o; pf = fclk_o; g = 0;
    @(negedge clk);
    while (fclk_o == pf && g < LIM) begin
      pb = bclk_o; @(negedge clk); g++;
    end
    check(g < LIM, "R3", g, LIM);
    check(fclk_o == 1'b1, "R3", fclk_o, 1);
    check(pb == 1'b1 && bclk_o == 1'b0, "R3", bclk_o, 0);
    check(frame_stb_o == 1'b1, "R10", frame_stb_o, 1);
    pb = bclk_o; pf = fclk_o; n = 0; g = 0;
    @(negedge clk);
    check(frame_stb_o == 1'b0, "R10", frame_stb_o, 0);
    while (g < LIM) begin
      if (pb && !bclk_o) n++;
      if (fclk_o != pf) break;
      pb = bclk_o; @(negedge clk); g++;
    end
    check(n == e.slot, "R3", n, e.slot);
    check(frame_stb_o == 1'b1, "R10", frame_stb_o, 1);
    // bit clock halves and edge pulses
    pb = bclk_o; g = 0;
    @(negedge clk);
    while (!(pb == 1'b0 && bclk_o == 1'b1) && g < LIM) begin
      pb = bclk_o; @(negedge clk); g++;
    end
    check(bclk_rise_o == 1'b1, "R9", bclk_rise_o, 1);
    hi = 0;
    while (bclk_o == 1'b1 && hi < LIM) begin
      hi++; @(negedge clk);
      if (hi == 1 && bclk_o == 1'b1) check(bclk_rise_o == 1'b0, "R9", bclk_rise_o, 0);
    end
    check(bclk_fall_o == 1'b1, "R9", bclk_fall_o, 1);
    lo = 0;
    while (bclk_o == 1'b0 && lo < LIM) begin lo++; @(negedge clk); end
    check(hi == e.bhalf, "R2", hi, e.bhalf);
    check(lo == e.bhalf, "R2", lo, e.bhalf);
    measure_mclk("R1");
  endtask

  // monitor: pops the expected item and compares against the outputs
  initial begin : monitor
    exp_t e;
    forever begin
      @(go_ev);
      e = exp_q.pop_front();
      check_case(e);
      ->done_ev;
    end
  end

  // driver: captures a configuration, queues its expectation, starts the port
  task automatic run_case(input int m, input bit f, input bit w, input bit change);
    @(negedge clk);
    run = 1'b0; gate = 1'b0; xfer = 1'b1;
    mult = 3'(m); fam3 = f; wide = w;
    repeat (3) @(negedge clk);
    exp_q.push_back(expect_of(m, f, w));
    run = 1'b1;
    ->go_ev;
    if (change) begin
      // R6: edits while running must be ignored
      mult = 3'd0; fam3 = 1'b1; wide = 1'b0;
    end
    @(done_ev);
    run = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int t, n;
    logic pm;
    rst_n = 1'b0; run = 1'b0; gate = 1'b1; xfer = 1'b0;
    mult = 3'd0; fam3 = 1'b0; wide = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    check({mclk_o, bclk_o, fclk_o, bclk_rise_o, bclk_fall_o, frame_stb_o} == 6'b0, "R8", mclk_o, 0);
    check(cfg_bad_o == 1'b0 && cfg_err_o == 1'b0, "R4", cfg_bad_o, 0);

    // R2: power-of-two family, narrow framing
    for (int c = 0; c <= 4; c++) run_case(c, 1'b0, 1'b0, 1'b0);
    // R2: three-times family, wide framing
    for (int c = 0; c <= 3; c++) run_case(c, 1'b1, 1'b1, 1'b0);
    run_case(0, 1'b1, 1'b0, 1'b0);
    // R5: non-integer divides
    run_case(3, 1'b1, 1'b0, 1'b0);
    run_case(1, 1'b0, 1'b1, 1'b0);
    // R4: illegal codes
    run_case(5, 1'b0, 1'b0, 1'b0);
    run_case(4, 1'b1, 1'b1, 1'b0);
    run_case(7, 1'b1, 1'b0, 1'b0);
    // R6: edits while running
    run_case(3, 1'b0, 1'b0, 1'b1);

    // R7: master clock runs early, bit and frame clocks stay low
    @(negedge clk);
    mult = 3'd3; fam3 = 1'b0; wide = 1'b0; xfer = 1'b0; gate = 1'b0;
    repeat (3) @(negedge clk);
    run = 1'b1;
    t = 0; n = 0; pm = mclk_o;
    repeat (100) begin
      @(negedge clk);
      if (mclk_o != pm) t++;
      pm = mclk_o;
      if (bclk_o | fclk_o) n++;
    end
    check(n == 0, "R7", n, 0);
    check(t > 40, "R7", t, 41);

    // R8: gate and run both stop every clock after one cycle
    xfer = 1'b1;
    repeat (200) @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
    check({mclk_o, bclk_o, fclk_o} == 3'b0, "R8", {mclk_o, bclk_o, fclk_o}, 0);
    gate = 1'b0;
    repeat (200) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check({mclk_o, bclk_o, fclk_o} == 3'b0, "R8", {mclk_o, bclk_o, fclk_o}, 0);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule